// File: doc/BRIEF.md
# Weekday-Masked Hour/Minute Alarm Unit

This block watches the current time that a timekeeper presents and raises an alarm when the time reaches a programmed minute and hour on an allowed day of the week. There are two alarm channels, A and B. They work the same way and do not affect each other. Each channel holds an alarm minute and an alarm hour. The hour uses the same encoding as the timekeeper's hour value, so a 12-hour value with its PM bit is compared as it is. Each channel also holds a seven-bit mask that selects the days of the week on which the alarm may fire.

A match is tested once per minute. The test happens on the timekeeper's update pulse when the seconds value is zero. A match sets a sticky pending flag for that channel. Each channel has an active-low interrupt output, which is low while that channel's flag and enable are both set. The two enables share one control register and the two flags share one status register. Software reads and writes all of these through a small indexed register port.

Top module: `alm_unit`

## Requirements
- R1: After reset, all alarm fields, both enables and both flags are zero, and `irq_a_n` and `irq_b_n` are high.
- R2: Alarm A's minute, hour and weekday mask are at indices 8, 9 and 10. Alarm B's are at indices 11, 12 and 13. The minute field keeps 7 bits, the hour field keeps 6 bits and the mask keeps 7 bits. Bits above a field read as 0, and indices 0 to 7 read as 0.
- R3: The control register is at index 14. Bit 7 enables channel A and bit 6 enables channel B. All its other bits read as 0.
- R4: A channel is tested only in a cycle where `tick` is high and `cur_sec` equals 0x00. The test passes when the stored minute equals `cur_min` and the stored hour equals `cur_hour` (raw encoding, including bit 5) and the mask bit indexed by `cur_wday` (0..6) is 1. A `cur_wday` of 7 never passes. A passing test sets the channel's flag on that clock edge.
- R5: A flag is set on a passing test even when its channel is disabled. In that case the interrupt output stays high.
- R6: The status register is at index 15. Bit 1 is channel A's flag and bit 0 is channel B's flag. A flag stays set until it is cleared. Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged.
- R7: Writing the control register with a channel's enable bit at 0 clears that channel's flag.
- R8: `irq_a_n` is low exactly when channel A's flag and enable are both 1. `irq_b_n` follows the same rule for channel B.
- R9: When a passing test and a clearing write reach the same flag in the same cycle, the flag is set.
- R10: Activity on one channel never changes the other channel's flag or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse: the current time values are fresh |
| cur_sec | input | 7 | Current seconds (BCD) |
| cur_min | input | 7 | Current minutes (BCD) |
| cur_hour | input | 6 | Current hour, timekeeper encoding |
| cur_wday | input | 3 | Current weekday, 0..6 |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_idx | input | 4 | Register read index |
| rd_data | output | 8 | Register read data (combinational) |
| irq_a_n | output | 1 | Channel A interrupt, active low |
| irq_b_n | output | 1 | Channel B interrupt, active low |

## Verification
The bench targets several corner cases:
- A tick at a non-zero second. A design that tests on every tick would fire up to 60 times per minute.
- A 12-hour PM hour compared against its 24-hour look-alike. A matcher that strips bit 5 would fire twelve hours early.
- Weekday 7, and masks that have only the current day's bit cleared. These catch faulty mask indexing.
- A flag clear and a match in the same cycle. A design with the wrong priority would lose that alarm.
- Writes of 1 to the status bits, and enabling a channel that already holds a flag. These confirm that a flag is neither created nor destroyed by the wrong write.

// File: rtl/alm_pkg.sv
package alm_pkg;

    parameter int DW       = 8;
    parameter int IW       = 4;
    parameter int NCH      = 2;
    parameter int MIN_W    = 7;
    parameter int HOUR_W   = 6;
    parameter int DAYS     = 7;
    parameter int WDAY_W   = 3;

    parameter int CH_BASE    = 8;
    parameter int CH_STRIDE  = 3;
    parameter int IDX_ENABLE = 14;
    parameter int IDX_STATUS = 15;
    parameter int EN_TOP     = 7;
    parameter int FLAG_TOP   = 1;

    typedef struct packed {
        logic [MIN_W-1:0]  minute;
        logic [HOUR_W-1:0] hour;
        logic [DAYS-1:0]   days;
    } alm_cfg_t;

    typedef struct packed {
        logic [MIN_W-1:0]  sec;
        logic [MIN_W-1:0]  minute;
        logic [HOUR_W-1:0] hour;
        logic [WDAY_W-1:0] wday;
    } tk_time_t;

    function automatic logic [IW-1:0] field_idx(input int ch, input int field);
        return IW'(CH_BASE + CH_STRIDE * ch + field);
    endfunction

    function automatic int en_pos(input int ch);
        return EN_TOP - ch;
    endfunction

    function automatic int flag_pos(input int ch);
        return FLAG_TOP - ch;
    endfunction

    function automatic logic day_allowed(input logic [DAYS-1:0] days,
                                         input logic [WDAY_W-1:0] wday);
        logic [(1<<WDAY_W)-1:0] wide;
        wide = '0;
        wide[DAYS-1:0] = days;
        return wide[wday];
    endfunction

endpackage

// File: rtl/alm_cfg_regs.sv
module alm_cfg_regs
    import alm_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [DAYS-1:0] wr_bits,
    output alm_cfg_t       cfg
);
    localparam logic [IW-1:0] IDX_MIN  = field_idx(CH, 0);
    localparam logic [IW-1:0] IDX_HOUR = field_idx(CH, 1);
    localparam logic [IW-1:0] IDX_DAYS = field_idx(CH, 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (wr_idx == IDX_MIN)  cfg.minute <= wr_bits[MIN_W-1:0];
            if (wr_idx == IDX_HOUR) cfg.hour   <= wr_bits[HOUR_W-1:0];
            if (wr_idx == IDX_DAYS) cfg.days   <= wr_bits;
        end
    end
endmodule

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  logic     tick,
    input  tk_time_t now,
    input  alm_cfg_t cfg,
    output logic     hit
);
    logic top_of_minute;
    logic time_eq;
    logic day_ok;

    always_comb begin
        top_of_minute = tick && (now.sec == '0);
        time_eq       = (cfg.minute == now.minute) && (cfg.hour == now.hour);
        day_ok        = day_allowed(cfg.days, now.wday);
        hit           = top_of_minute && time_eq && day_ok;
    end
endmodule

// File: rtl/alm_chan_ctl.sv
module alm_chan_ctl (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic wr_enable_reg,
    input  logic wr_status_reg,
    input  logic en_bit,
    input  logic flag_bit,
    output logic en,
    output logic flag,
    output logic irq_n
);
    logic clear_req;

    always_comb begin
        clear_req = (wr_enable_reg && !en_bit) || (wr_status_reg && !flag_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (wr_enable_reg) en <= en_bit;
            if (hit)            flag <= 1'b1;
            else if (clear_req) flag <= 1'b0;
        end
    end

    always_comb begin
        irq_n = !(en && flag);
    end
endmodule

// File: rtl/alm_unit.sv
module alm_unit
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [MIN_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic              irq_a_n,
    output logic              irq_b_n
);
    localparam logic [IW-1:0] IDX_EN = IW'(IDX_ENABLE);
    localparam logic [IW-1:0] IDX_ST = IW'(IDX_STATUS);

    tk_time_t        now;
    alm_cfg_t        cfg_w  [NCH];
    logic [NCH-1:0]  hit_w;
    logic [NCH-1:0]  en_w;
    logic [NCH-1:0]  flag_w;
    logic [NCH-1:0]  irqn_w;
    logic [NCH-1:0]  en_wdata;
    logic [NCH-1:0]  flag_wdata;
    logic            wr_enable_reg;
    logic            wr_status_reg;
    logic            unused_wr_msb;

    assign now           = '{sec: cur_sec, minute: cur_min, hour: cur_hour, wday: cur_wday};
    assign wr_enable_reg = wr_en && (wr_idx == IDX_EN);
    assign wr_status_reg = wr_en && (wr_idx == IDX_ST);
    assign unused_wr_msb = wr_data[DW-1];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign en_wdata[c]   = wr_data[en_pos(c)];
        assign flag_wdata[c] = wr_data[flag_pos(c)];

        alm_cfg_regs #(.CH(c)) u_cfg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_bits (wr_data[DAYS-1:0]),
            .cfg     (cfg_w[c])
        );

        alm_match u_match (
            .tick (tick),
            .now  (now),
            .cfg  (cfg_w[c]),
            .hit  (hit_w[c])
        );

        alm_chan_ctl u_ctl (
            .clk           (clk),
            .rst           (rst),
            .hit           (hit_w[c]),
            .wr_enable_reg (wr_enable_reg),
            .wr_status_reg (wr_status_reg),
            .en_bit        (en_wdata[c]),
            .flag_bit      (flag_wdata[c]),
            .en            (en_w[c]),
            .flag          (flag_w[c]),
            .irq_n         (irqn_w[c])
        );
    end

    assign irq_a_n = irqn_w[0];
    assign irq_b_n = irqn_w[1];

    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_EN) begin
            for (int c = 0; c < NCH; c++) rd_data[en_pos(c)] = en_w[c];
        end else if (rd_idx == IDX_ST) begin
            for (int c = 0; c < NCH; c++) rd_data[flag_pos(c)] = flag_w[c];
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (rd_idx == field_idx(c, 0)) rd_data = DW'(cfg_w[c].minute);
                if (rd_idx == field_idx(c, 1)) rd_data = DW'(cfg_w[c].hour);
                if (rd_idx == field_idx(c, 2)) rd_data = DW'(cfg_w[c].days);
            end
        end
    end
endmodule

// File: rtl/alm_unit_chk.sv
module alm_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] hit,
    input logic [1:0] en,
    input logic [1:0] flag,
    input logic [1:0] irq_n,
    input logic [1:0] en_wdata,
    input logic       wr_enable_reg,
    input logic       wr_status_reg
);
    for (genvar c = 0; c < 2; c++) begin : g_chk
        // R4
        match_sets_chk: assert property (@(posedge clk) disable iff (rst)
            hit[c] |=> flag[c]);

        // R6
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (flag[c] && !wr_enable_reg && !wr_status_reg) |=> flag[c]);

        // R7
        disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_enable_reg && !en_wdata[c] && !hit[c]) |=> !flag[c]);

        // R5
        flag_source_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(flag[c]) |-> $past(hit[c]));

        // R8
        irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(irq_n[c]) |-> ($past(hit[c] && en[c]) ||
                                 $past(wr_enable_reg && en_wdata[c] && flag[c])));
    end
endmodule

bind alm_unit alm_unit_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .hit           (hit_w),
    .en            (en_w),
    .flag          (flag_w),
    .irq_n         (irqn_w),
    .en_wdata      (en_wdata),
    .wr_enable_reg (wr_enable_reg),
    .wr_status_reg (wr_status_reg)
);

// File: tb/sim_alm_unit.sv
module sim_alm_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // {sec, min, hour, wday, alarm_min, alarm_hour, alarm_days, expect}
    localparam logic [63:0] VEC [NVEC] = '{
        64'h00_30_12_03_30_12_7F_01,
        64'h01_30_12_03_30_12_7F_00,
        64'h00_31_12_03_30_12_7F_00,
        64'h00_30_13_03_30_12_7F_00,
        64'h00_30_12_03_30_12_08_01,
        64'h00_30_12_03_30_12_77_00,
        64'h00_30_32_03_30_12_7F_00,
        64'h00_30_32_03_30_32_7F_01,
        64'h00_30_12_07_30_12_7F_00,
        64'h00_45_08_00_45_08_01_01,
        64'h00_45_08_06_45_08_40_01,
        64'h00_59_23_05_59_23_5F_00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [6:0] cur_sec = 7'h01;
    logic [6:0] cur_min = 7'h00;
    logic [5:0] cur_hour = 6'h00;
    logic [2:0] cur_wday = 3'd0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       irq_a_n, irq_b_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    alm_unit u0 (.*);

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] data);
        @(negedge clk);
        rd_idx = idx;
        #1 data = rd_data;
    endtask

    task automatic tick_at(input logic [6:0] s, input logic [6:0] m,
                           input logic [5:0] h, input logic [2:0] w);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; cur_sec = 7'h01;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 8; i < 16; i++) begin
            rd(4'(i), d);
            check("R1 reg after reset", d, 8'h00);
        end
        check("R1 irq_a_n after reset", {7'b0, irq_a_n}, 8'h01);
        check("R1 irq_b_n after reset", {7'b0, irq_b_n}, 8'h01);

        // R4 table walk on channel A
        for (int v = 0; v < NVEC; v++) begin
            wr(4'd14, 8'h00);
            wr(4'd8,  VEC[v][31:24]);
            wr(4'd9,  VEC[v][23:16]);
            wr(4'd10, VEC[v][15:8]);
            wr(4'd14, 8'h80);
            tick_at(VEC[v][62:56], VEC[v][54:48], VEC[v][45:40], VEC[v][34:32]);
            rd(4'd15, d);
            check($sformatf("R4 vector %0d flag", v), {7'b0, d[1]}, VEC[v][7:0]);
            check($sformatf("R8 vector %0d irq_a_n", v), {7'b0, irq_a_n}, {7'b0, ~VEC[v][0]});
        end

        // R2 register map and field widths
        wr(4'd11, 8'hFF); wr(4'd12, 8'hFF); wr(4'd13, 8'hFF);
        rd(4'd11, d); check("R2 B minute width", d, 8'h7F);
        rd(4'd12, d); check("R2 B hour width", d, 8'h3F);
        rd(4'd13, d); check("R2 B days width", d, 8'h7F);
        rd(4'd8, d);  check("R2 A minute untouched", d, 8'h59);
        wr(4'd3, 8'hAA);
        rd(4'd3, d);  check("R2 low index reads zero", d, 8'h00);

        // R3 control register bits
        wr(4'd14, 8'hFF);
        rd(4'd14, d); check("R3 control readback", d, 8'hC0);
        wr(4'd14, 8'h00);

        // R5 polled flag while disabled
        wr(4'd8, 8'h10); wr(4'd9, 8'h05); wr(4'd10, 8'h7F);
        tick_at(7'h00, 7'h10, 6'h05, 3'd2);
        rd(4'd15, d);
        check("R5 flag set while disabled", {7'b0, d[1]}, 8'h01);
        check("R5 irq high while disabled", {7'b0, irq_a_n}, 8'h01);
        wr(4'd14, 8'h80);
        check("R8 enabling pending flag drives irq", {7'b0, irq_a_n}, 8'h00);

        // R6 sticky, write 1 no effect, write 0 clears
        tick_at(7'h00, 7'h11, 6'h05, 3'd2);
        rd(4'd15, d);
        check("R6 flag sticky across non-match", {7'b0, d[1]}, 8'h01);
        wr(4'd15, 8'h02);
        rd(4'd15, d);
        check("R6 write 1 keeps flag", {7'b0, d[1]}, 8'h01);
        wr(4'd15, 8'h00);
        rd(4'd15, d);
        check("R6 write 0 clears flag", {7'b0, d[1]}, 8'h00);
        check("R8 irq released after clear", {7'b0, irq_a_n}, 8'h01);
        wr(4'd15, 8'h03);
        rd(4'd15, d);
        check("R6 write 1 sets nothing", d, 8'h00);

        // R10 channel B independent
        wr(4'd11, 8'h20); wr(4'd12, 8'h07); wr(4'd13, 8'h10);
        wr(4'd14, 8'hC0);
        tick_at(7'h00, 7'h20, 6'h07, 3'd4);
        rd(4'd15, d);
        check("R10 only B flag set", d, 8'h01);
        check("R10 irq_b_n low", {7'b0, irq_b_n}, 8'h00);
        check("R10 irq_a_n high", {7'b0, irq_a_n}, 8'h01);

        // R7 disable clears only that channel
        tick_at(7'h00, 7'h10, 6'h05, 3'd2);
        wr(4'd14, 8'h80);
        rd(4'd15, d);
        check("R7 disable B clears B only", d, 8'h02);
        check("R7 irq_b_n high after disable", {7'b0, irq_b_n}, 8'h01);
        wr(4'd15, 8'h01);
        rd(4'd15, d);
        check("R10 status write keeps B bit semantics", d, 8'h00);

        // R9 match wins over same-cycle clear
        @(negedge clk);
        cur_sec = 7'h00; cur_min = 7'h10; cur_hour = 6'h05; cur_wday = 3'd2; tick = 1'b1;
        wr_en = 1'b1; wr_idx = 4'd15; wr_data = 8'h00;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; cur_sec = 7'h01;
        rd(4'd15, d);
        check("R9 set wins over clear", {7'b0, d[1]}, 8'h01);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule